// File: doc/BRIEF.md
# FIFO Watermark Interrupt Status Unit

This block is the interrupt front end of a FIFO-based serial controller. It watches the fill levels of a transmit FIFO and a receive FIFO, compares each one with a programmable watermark, notes when either FIFO is full, and latches two error events: a write into a full receive FIFO and a read from an empty transmit FIFO. All six conditions appear in one status word that software reads over a simple register port.

Software picks which conditions may interrupt. It sets mask bits through one write-only address, clears them through another, and reads the current mask at a third. The two event bits are sticky and are cleared by writing 1s to the status address. The four level bits track the FIFOs on every cycle, so software cannot clear them. A single level-sensitive interrupt line is high while any unmasked status bit is set.

Top module: `qirq_status_unit`

## Requirements
- R1: While reset is held, status (0x04) and mask (0x10) read 0, both watermarks (0x28, 0x2C) read 1, and `irq` is low.
- R2: Status bit 2 is 1 in the cycle after the transmit level is strictly below the transmit watermark (0x28), and 0 otherwise. A watermark of 0 keeps it at 0.
- R3: Status bit 3 is 1 in the cycle after the transmit level equals DEPTH (63). Status bit 5 is 1 in the cycle after the receive level equals DEPTH.
- R4: Status bit 4 is 1 in the cycle after the receive level is at or above the receive watermark (0x2C). A watermark of 0 keeps it at 1.
- R5: A one-cycle pulse on `rx_ovf_evt` sets status bit 0, and one on `tx_unf_evt` sets status bit 6. Each bit then stays 1 until software clears it.
- R6: Writing to 0x04 clears each sticky bit (0 or 6) whose data bit is 1. Bits written as 0 keep their value, and the live bits 2 to 5 are not changed by the write.
- R7: If an event pulse arrives in the same cycle as a write that clears its bit, the bit stays set.
- R8: Writing 0x08 ORs the data into the mask and writing 0x0C removes the data's 1 bits from the mask. The mask reads at 0x10 on bits 6:0, and bit 1 and bits 31:7 always read 0.
- R9: `irq` is high exactly when some bit is set in both status and mask, and it follows those registers in the same cycle.
- R10: The watermark registers at 0x28 and 0x2C keep bits 5:0 of the written data and read back the kept value.
- R11: A write to the mask readback address 0x10 changes nothing, and reads from unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| tx_level | input | 6 | Current transmit FIFO fill level |
| rx_level | input | 6 | Current receive FIFO fill level |
| rx_ovf_evt | input | 1 | One-cycle pulse: receive FIFO overflowed |
| tx_unf_evt | input | 1 | One-cycle pulse: transmit FIFO underflowed |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can reach a sticky status bit in the same cycle: a new overflow or underflow event that sets it, and a software write to 0x04 that clears it. The bench provokes this by driving the event pulse in the same cycle as the clearing write, once for each sticky bit. It expects the bit to read 1 after that edge and to clear only on a later write that has no event beside it. Across both transmit and receive levels, every watermark is swept against every fill level, and the expected level bits are worked out from plain comparisons.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
  localparam int NFLAG = 7;

  localparam logic [7:0] OFS_STATUS  = 8'h04;
  localparam logic [7:0] OFS_MSET    = 8'h08;
  localparam logic [7:0] OFS_MCLR    = 8'h0C;
  localparam logic [7:0] OFS_MREAD   = 8'h10;
  localparam logic [7:0] OFS_TXMARK  = 8'h28;
  localparam logic [7:0] OFS_RXMARK  = 8'h2C;

  localparam int B_RXOVF   = 0;
  localparam int B_TXLOW   = 2;
  localparam int B_TXFULL  = 3;
  localparam int B_RXAVAIL = 4;
  localparam int B_RXFULL  = 5;
  localparam int B_TXUNF   = 6;

  localparam logic [NFLAG-1:0] VALID_BITS  = 7'b111_1101;
  localparam logic [NFLAG-1:0] STICKY_BITS = 7'b100_0001;

  function automatic logic below_mark(int unsigned lvl, int unsigned mark);
    return lvl < mark;
  endfunction

  function automatic logic reaches_mark(int unsigned lvl, int unsigned mark);
    return lvl >= mark;
  endfunction

  function automatic logic is_full(int unsigned lvl, int unsigned depth);
    return lvl == depth;
  endfunction
endpackage

// File: rtl/qirq_wr_decode.sv
module qirq_wr_decode
  import qirq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 6
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NFLAG-1:0]  stat_clr,
  output logic [NFLAG-1:0]  mask_set,
  output logic [NFLAG-1:0]  mask_clr,
  output logic              txmark_we,
  output logic              rxmark_we,
  output logic [LVL_W-1:0]  mark_val
);
  logic hit_status, hit_mset, hit_mclr;
  logic unused_hi;

  assign hit_status = wr_en && (wr_addr == ADDR_W'(OFS_STATUS));
  assign hit_mset   = wr_en && (wr_addr == ADDR_W'(OFS_MSET));
  assign hit_mclr   = wr_en && (wr_addr == ADDR_W'(OFS_MCLR));
  assign txmark_we  = wr_en && (wr_addr == ADDR_W'(OFS_TXMARK));
  assign rxmark_we  = wr_en && (wr_addr == ADDR_W'(OFS_RXMARK));

  assign stat_clr = hit_status ? (wr_data[NFLAG-1:0] & STICKY_BITS) : '0;
  assign mask_set = hit_mset   ? (wr_data[NFLAG-1:0] & VALID_BITS)  : '0;
  assign mask_clr = hit_mclr   ? (wr_data[NFLAG-1:0] & VALID_BITS)  : '0;
  assign mark_val = wr_data[LVL_W-1:0];

  assign unused_hi = ^wr_data[DATA_W-1:NFLAG];
endmodule

// File: rtl/qirq_mark_reg.sv
module qirq_mark_reg #(
  parameter int LVL_W = 6,
  parameter int RESET_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LVL_W-1:0] val,
  output logic [LVL_W-1:0] mark_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mark_q <= LVL_W'(RESET_VAL);
    else if (we) mark_q <= val;
  end
endmodule

// File: rtl/qirq_mask.sv
module qirq_mask
  import qirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] mask_set,
  input  logic [NFLAG-1:0] mask_clr,
  output logic [NFLAG-1:0] mask_q
);
  logic [NFLAG-1:0] mask_n;

  // clear is applied after set, so clear takes priority
  assign mask_n = ((mask_q | mask_set) & ~mask_clr) & VALID_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_n;
  end
endmodule

// File: rtl/qirq_flags.sv
module qirq_flags
  import qirq_pkg::*;
#(
  parameter int DEPTH = 63,
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_mark,
  input  logic [LVL_W-1:0] rx_mark,
  input  logic             rx_ovf_evt,
  input  logic             tx_unf_evt,
  input  logic [NFLAG-1:0] stat_clr,
  output logic [NFLAG-1:0] status_q
);
  logic [NFLAG-1:0] live_n;
  logic [NFLAG-1:0] evt_vec;
  logic [NFLAG-1:0] status_n;
  logic             unused_clr;

  always_comb begin
    live_n = '0;
    live_n[B_TXLOW]   = below_mark(32'(tx_level), 32'(tx_mark));
    live_n[B_TXFULL]  = is_full(32'(tx_level), DEPTH);
    live_n[B_RXAVAIL] = reaches_mark(32'(rx_level), 32'(rx_mark));
    live_n[B_RXFULL]  = is_full(32'(rx_level), DEPTH);
  end

  always_comb begin
    evt_vec = '0;
    evt_vec[B_RXOVF] = rx_ovf_evt;
    evt_vec[B_TXUNF] = tx_unf_evt;
  end

  // a new event beats a software clear of the same bit
  genvar b;
  generate
    for (b = 0; b < NFLAG; b++) begin : g_bit
      if (STICKY_BITS[b]) begin : g_sticky
        assign status_n[b] = evt_vec[b] | (status_q[b] & ~stat_clr[b]);
      end else if (VALID_BITS[b]) begin : g_live
        assign status_n[b] = live_n[b];
      end else begin : g_none
        assign status_n[b] = 1'b0;
      end
    end
  endgenerate

  assign unused_clr = ^(stat_clr & ~STICKY_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_n;
  end
endmodule

// File: rtl/qirq_status_unit.sv
module qirq_status_unit
  import qirq_pkg::*;
#(
  parameter int DEPTH  = 63,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_ovf_evt,
  input  logic              tx_unf_evt,
  output logic              irq
);
  logic [NFLAG-1:0] stat_clr, mask_set, mask_clr;
  logic [NFLAG-1:0] status_q, mask_q;
  logic             txmark_we, rxmark_we;
  logic [LVL_W-1:0] mark_val, tx_mark, rx_mark;
  logic [NFLAG-1:0] pending;

  qirq_wr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat_clr(stat_clr), .mask_set(mask_set), .mask_clr(mask_clr),
    .txmark_we(txmark_we), .rxmark_we(rxmark_we), .mark_val(mark_val)
  );

  qirq_mark_reg #(.LVL_W(LVL_W), .RESET_VAL(1)) u_txmark (
    .clk(clk), .rst_n(rst_n), .we(txmark_we), .val(mark_val), .mark_q(tx_mark)
  );

  qirq_mark_reg #(.LVL_W(LVL_W), .RESET_VAL(1)) u_rxmark (
    .clk(clk), .rst_n(rst_n), .we(rxmark_we), .val(mark_val), .mark_q(rx_mark)
  );

  qirq_mask u_mask (
    .clk(clk), .rst_n(rst_n), .mask_set(mask_set), .mask_clr(mask_clr),
    .mask_q(mask_q)
  );

  qirq_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .tx_mark(tx_mark), .rx_mark(rx_mark), .rx_ovf_evt(rx_ovf_evt),
    .tx_unf_evt(tx_unf_evt), .stat_clr(stat_clr), .status_q(status_q)
  );

  assign pending = status_q & mask_q;
  assign irq     = |pending;

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(OFS_STATUS))      rd_data = DATA_W'(status_q);
    else if (rd_addr == ADDR_W'(OFS_MREAD))  rd_data = DATA_W'(mask_q);
    else if (rd_addr == ADDR_W'(OFS_TXMARK)) rd_data = DATA_W'(tx_mark);
    else if (rd_addr == ADDR_W'(OFS_RXMARK)) rd_data = DATA_W'(rx_mark);
  end
endmodule

// File: rtl/qirq_status_chk.sv
module qirq_status_chk
  import qirq_pkg::*;
#(
  parameter int DEPTH = 63,
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] tx_mark,
  input logic             rx_ovf_evt,
  input logic             tx_unf_evt,
  input logic [NFLAG-1:0] stat_clr,
  input logic [NFLAG-1:0] mask_set,
  input logic [NFLAG-1:0] mask_clr,
  input logic [NFLAG-1:0] status_q,
  input logic [NFLAG-1:0] mask_q,
  input logic             irq
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_tx_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> status_q[B_TXLOW] == ($past(tx_level) < $past(tx_mark)));

  assert_tx_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> status_q[B_TXFULL] == ($past(tx_level) == LVL_W'(DEPTH)));

  assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[B_RXOVF] && !stat_clr[B_RXOVF]) |=> status_q[B_RXOVF]);

  assert_ovf_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf_evt |=> status_q[B_RXOVF]);

  assert_unf_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_unf_evt |=> status_q[B_TXUNF]);

  assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_set & ~mask_clr) != '0) |=>
      ((mask_q & $past(mask_set & ~mask_clr)) == $past(mask_set & ~mask_clr)));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[B_TXUNF] && mask_q[B_TXUNF]) |-> irq);
endmodule

bind qirq_status_unit qirq_status_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .tx_mark(tx_mark),
  .rx_ovf_evt(rx_ovf_evt), .tx_unf_evt(tx_unf_evt), .stat_clr(stat_clr),
  .mask_set(mask_set), .mask_clr(mask_clr), .status_q(status_q),
  .mask_q(mask_q), .irq(irq)
);

// File: tb/tb_qirq_status_unit.sv
`timescale 1ns/100ps
module tb_qirq_status_unit;
  localparam int DEPTH = 63;
  localparam int LVL_W = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = 8'h04;
  logic [31:0] rd_data;
  logic [LVL_W-1:0] tx_level = '0;
  logic [LVL_W-1:0] rx_level = '0;
  logic        rx_ovf_evt = 1'b0;
  logic        tx_unf_evt = 1'b0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  qirq_status_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_level(tx_level), .rx_level(rx_level), .rx_ovf_evt(rx_ovf_evt),
    .tx_unf_evt(tx_unf_evt), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #0.5;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #0.5;
    wr_en = 1'b0;
  endtask

  task automatic set_levels(input int tl, input int rl);
    @(negedge clk);
    tx_level = LVL_W'(tl); rx_level = LVL_W'(rl);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp;

    // R1: values while reset is held
    repeat (3) @(posedge clk); #0.5;
    rd(8'h04, d); check("R1 status", d, 0);
    rd(8'h10, d); check("R1 mask", d, 0);
    rd(8'h28, d); check("R1 tx mark", d, 1);
    rd(8'h2C, d); check("R1 rx mark", d, 1);
    check("R1 irq", 32'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    tick();

    // R2 R3 R10: every transmit watermark against every transmit level
    for (int wm = 0; wm <= DEPTH; wm++) begin
      wr(8'h28, 32'hFFFF_FFC0 | 32'(wm));
      rd(8'h28, d); check("R10 tx mark readback", d, 32'(wm));
      for (int lv = 0; lv <= DEPTH; lv++) begin
        set_levels(lv, 0);
        exp = ((lv < wm) ? 32'h04 : 0) | ((lv == DEPTH) ? 32'h08 : 0);
        rd(8'h04, d); check("R2 R3 tx bits", d, exp);
      end
    end
    wr(8'h28, 1);

    // R3 R4 R10: every receive watermark against every receive level
    for (int wm = 0; wm <= DEPTH; wm++) begin
      wr(8'h2C, 32'(wm));
      rd(8'h2C, d); check("R10 rx mark readback", d, 32'(wm));
      for (int lv = 0; lv <= DEPTH; lv++) begin
        set_levels(5, lv);
        exp = ((lv >= wm) ? 32'h10 : 0) | ((lv == DEPTH) ? 32'h20 : 0);
        rd(8'h04, d); check("R3 R4 rx bits", d, exp);
      end
    end
    wr(8'h2C, 1);
    set_levels(5, 0);
    rd(8'h04, d); check("R4 idle status", d, 0);

    // R5: sticky events
    @(negedge clk); rx_ovf_evt = 1'b1; tick(); rx_ovf_evt = 1'b0;
    rd(8'h04, d); check("R5 overflow set", d, 32'h01);
    repeat (4) tick();
    rd(8'h04, d); check("R5 overflow held", d, 32'h01);
    @(negedge clk); tx_unf_evt = 1'b1; tick(); tx_unf_evt = 1'b0;
    rd(8'h04, d); check("R5 underflow set", d, 32'h41);

    // R6: write-one-to-clear, zeros keep, live bits untouched
    wr(8'h04, 32'h0000_0040);
    rd(8'h04, d); check("R6 clear bit6 only", d, 32'h01);
    set_levels(0, 63);
    wr(8'h04, 32'h0000_003C);
    rd(8'h04, d); check("R6 live bits kept", d, 32'h35);
    wr(8'h04, 32'h0000_0001);
    rd(8'h04, d); check("R6 clear bit0", d, 32'h34);
    set_levels(5, 0);

    // R7: event and clear in the same cycle
    @(negedge clk); rx_ovf_evt = 1'b1; tick(); rx_ovf_evt = 1'b0;
    @(negedge clk);
    rx_ovf_evt = 1'b1; wr_en = 1'b1; wr_addr = 8'h04; wr_data = 32'h01;
    tick(); rx_ovf_evt = 1'b0; wr_en = 1'b0;
    rd(8'h04, d); check("R7 overflow survives clear", d, 32'h01);
    @(negedge clk); tx_unf_evt = 1'b1; wr_en = 1'b1; wr_addr = 8'h04; wr_data = 32'h40;
    tick(); tx_unf_evt = 1'b0; wr_en = 1'b0;
    rd(8'h04, d); check("R7 underflow survives clear", d, 32'h41);
    wr(8'h04, 32'h41);
    rd(8'h04, d); check("R7 later clear works", d, 0);

    // R8: mask set and clear
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R8 mask set all", d, 32'h7D);
    wr(8'h0C, 32'h0000_0041);
    rd(8'h10, d); check("R8 mask partial clear", d, 32'h3C);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R8 mask clear all", d, 0);
    wr(8'h08, 32'h0000_0012);
    rd(8'h10, d); check("R8 mask bit1 dropped", d, 32'h10);
    wr(8'h0C, 32'h10);

    // R11: readback address is not writable, unmapped reads 0
    wr(8'h10, 32'h7F);
    rd(8'h10, d); check("R11 readback unwritable", d, 0);
    rd(8'h00, d); check("R11 unmapped 0x00", d, 0);
    rd(8'h30, d); check("R11 unmapped 0x30", d, 0);
    check("R11 irq after stray write", 32'(irq), 0);

    // R9: interrupt output
    set_levels(0, 0);
    check("R9 unmasked status no irq", 32'(irq), 0);
    wr(8'h08, 32'h04);
    check("R9 tx low masked in", 32'(irq), 1);
    set_levels(5, 0);
    check("R9 irq follows live bit", 32'(irq), 0);
    wr(8'h08, 32'h40);
    @(negedge clk); tx_unf_evt = 1'b1; tick(); tx_unf_evt = 1'b0;
    check("R9 irq on underflow", 32'(irq), 1);
    wr(8'h0C, 32'h40);
    check("R9 irq after mask clear", 32'(irq), 0);
    wr(8'h08, 32'h40);
    check("R9 irq after mask restore", 32'(irq), 1);
    wr(8'h04, 32'h40);
    check("R9 irq after status clear", 32'(irq), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule